// File: doc/BRIEF.md
# Bus Machine Cycle Sequencer

This block runs the bus machine cycles of a small 8-bit processor. The control unit asks for one of three cycle kinds: an opcode fetch, a memory read or a memory write. The sequencer then drives the memory bus through a fixed pattern of clock states. It stretches that pattern with wait states for as long as memory reports that it is not ready. When the cycle completes, it raises a one-clock completion pulse.

An opcode fetch takes its address from an internal program counter. It loads the returned byte into both the data register and the instruction register. The program counter then advances to the next byte, and one extra decode clock follows before the cycle completes. A read takes its address from the request and stores the returned byte only in the data register. A write places the request data on the bus and holds it there for the whole cycle.

Requests are taken only while the sequencer is idle. Decoding, arithmetic and the sequencing of multi-byte instructions belong to other blocks.

Top module: `bus_cycle_seq`

## Requirements
- R1: While reset is high and on the first clock after it, both strobes and `done` are low. `pc_out` equals `RESET_PC`, and `ir_out` and `rd_byte` are zero.
- R2: An opcode fetch with memory ready lasts four clocks counted from the clock after acceptance: three bus clocks and then one decode clock. `done` is high only on the fourth clock.
- R3: A read or a write with memory ready lasts three clocks counted from the clock after acceptance. `done` is high only on the third clock.
- R4: `mem_ready` is sampled at the end of the second bus clock and at the end of each wait clock. Each low sample adds exactly one wait clock. During a wait clock the active strobe and `mem_addr` hold their values.
- R5: For a fetch or a read, `mem_rd` is high on the second bus clock, on every wait clock and on the third bus clock, and at no other time. `mem_wr` stays low, and the two strobes are never high together.
- R6: For a write, `mem_wr` is high on the same clocks as described in R5, and `mem_rd` stays low. `mem_wdata` equals the request data on every clock that `mem_wr` is high.
- R7: A fetch drives `pc_out` onto `mem_addr`. After the fetch, `pc_out` is one higher, wrapping modulo 2^ADDR_W. Reads, writes and ignored requests leave `pc_out` unchanged.
- R8: The byte present on `mem_rdata` during the last bus clock of a fetch appears on `ir_out` in the decode clock. It also appears on `rd_byte`. A read updates only `rd_byte`, on the clock after `done`. A write changes neither `ir_out` nor `rd_byte`.
- R9: `done` is high for exactly one clock per machine cycle and never on two clocks in a row.
- R10: `req_kind` is coded as 0 fetch, 1 read and 2 write. A request is taken only when `req_valid` is high in the idle state. Code 3 starts no cycle. Requests made while a cycle is running have no effect on that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Cycle request from the control unit |
| req_kind | input | 2 | Cycle kind: 0 fetch, 1 read, 2 write, 3 none |
| req_addr | input | ADDR_W | Address for a read or a write |
| req_wdata | input | DATA_W | Data for a write |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_rdata | input | DATA_W | Data returned by memory |
| mem_wdata | output | DATA_W | Data driven to memory |
| mem_rd | output | 1 | Read strobe |
| mem_wr | output | 1 | Write strobe |
| mem_ready | input | 1 | Memory ready; low inserts wait clocks |
| done | output | 1 | One-clock completion pulse |
| rd_byte | output | DATA_W | Data register, the last byte fetched or read |
| ir_out | output | DATA_W | Instruction register |
| pc_out | output | ADDR_W | Program counter |

## Verification
The bench builds the block with an 8-bit address and a reset program counter of 0xFC. This lets a short run of fetches carry the counter past 0xFF and back to zero. A 256-byte memory model also covers every reachable address, so a byte that a write stores can be read back and compared. Wait counts from zero to six, together with request noise injected during running cycles, exercise the cycle stretching and the rule that requests are ignored while busy.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
    typedef enum logic [1:0] {
        KIND_FETCH = 2'd0,
        KIND_READ  = 2'd1,
        KIND_WRITE = 2'd2,
        KIND_NONE  = 2'd3
    } bus_kind_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_T1,
        PH_T2,
        PH_TW,
        PH_T3,
        PH_T4
    } bus_phase_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic done;
        logic capture;
        logic load_ir;
        logic pc_step;
    } seq_ctl_t;

    function automatic logic kind_starts(input bus_kind_e k);
        return (k != KIND_NONE);
    endfunction
endpackage

// File: rtl/bcs_sequencer.sv
module bcs_sequencer
    import bcs_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      req_valid,
    input  bus_kind_e req_kind,
    input  logic      mem_ready,
    output logic      accept,
    output seq_ctl_t  ctl
);
    bus_phase_e phase_q, phase_d;
    bus_kind_e  kind_q;

    assign accept = (phase_q == PH_IDLE) && req_valid && kind_starts(req_kind);

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: if (accept) phase_d = PH_T1;
            PH_T1:   phase_d = PH_T2;
            PH_T2:   phase_d = mem_ready ? PH_T3 : PH_TW;
            PH_TW:   phase_d = mem_ready ? PH_T3 : PH_TW;
            PH_T3:   phase_d = (kind_q == KIND_FETCH) ? PH_T4 : PH_IDLE;
            PH_T4:   phase_d = PH_IDLE;
            default: phase_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            kind_q  <= KIND_NONE;
        end else begin
            phase_q <= phase_d;
            if (accept) kind_q <= req_kind;
        end
    end

    logic on_bus;
    assign on_bus = (phase_q == PH_T2) || (phase_q == PH_TW) || (phase_q == PH_T3);

    always_comb begin
        ctl.rd      = on_bus && (kind_q != KIND_WRITE);
        ctl.wr      = on_bus && (kind_q == KIND_WRITE);
        ctl.done    = ((phase_q == PH_T3) && (kind_q != KIND_FETCH)) || (phase_q == PH_T4);
        ctl.capture = (phase_q == PH_T3) && (kind_q != KIND_WRITE);
        ctl.load_ir = (phase_q == PH_T3) && (kind_q == KIND_FETCH);
        ctl.pc_step = (phase_q == PH_T3) && (kind_q == KIND_FETCH);
    end
endmodule

// File: rtl/bcs_datapath.sv
module bcs_datapath
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  bus_kind_e         req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  seq_ctl_t          ctl,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] ir_q,
    output logic [ADDR_W-1:0] pc_q
);
    localparam logic [ADDR_W-1:0] PC_ONE = ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            wdata_q <= '0;
            data_q  <= '0;
            ir_q    <= '0;
            pc_q    <= RESET_PC;
        end else begin
            if (accept) begin
                addr_q  <= (req_kind == KIND_FETCH) ? pc_q : req_addr;
                wdata_q <= req_wdata;
            end
            if (ctl.capture) data_q <= mem_rdata;
            if (ctl.load_ir) ir_q   <= mem_rdata;
            if (ctl.pc_step) pc_q   <= pc_q + PC_ONE;
        end
    end
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] RESET_PC = '0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    input  logic              mem_ready,
    output logic              done,
    output logic [DATA_W-1:0] rd_byte,
    output logic [DATA_W-1:0] ir_out,
    output logic [ADDR_W-1:0] pc_out
);
    bus_kind_e kind_in;
    logic      accept;
    seq_ctl_t  ctl;

    assign kind_in = bus_kind_e'(req_kind);

    bcs_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_kind  (kind_in),
        .mem_ready (mem_ready),
        .accept    (accept),
        .ctl       (ctl)
    );

    bcs_datapath #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .RESET_PC (RESET_PC)
    ) u_dp (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .req_kind  (kind_in),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .ctl       (ctl),
        .mem_rdata (mem_rdata),
        .addr_q    (mem_addr),
        .wdata_q   (mem_wdata),
        .data_q    (rd_byte),
        .ir_q      (ir_out),
        .pc_q      (pc_out)
    );

    assign mem_rd = ctl.rd;
    assign mem_wr = ctl.wr;
    assign done   = ctl.done;
endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              done,
    input logic [DATA_W-1:0] ir_out,
    input logic [ADDR_W-1:0] pc_out
);
    // R5: the two strobes never overlap
    assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    // R9: the completion pulse never lasts two clocks
    assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: the address holds while a strobe stays active
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        ((mem_rd || mem_wr) && ($past(mem_rd) || $past(mem_wr))) |-> $stable(mem_addr));

    // R6: the write data holds while the write strobe stays active
    assert_wdata_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && $past(mem_wr)) |-> $stable(mem_wdata));

    // R7: the program counter only moves by one step
    assert_pc_step_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(pc_out) |-> (pc_out == ADDR_W'($past(pc_out) + 1'b1)));

    // R8: the instruction register only changes on the decode clock
    assert_ir_on_done_R8: assert property (@(posedge clk) disable iff (rst)
        !$stable(ir_out) |-> done);
endmodule

bind bus_cycle_seq bcs_checker #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rd    (mem_rd),
    .mem_wr    (mem_wr),
    .done      (done),
    .ir_out    (ir_out),
    .pc_out    (pc_out)
);

// File: tb/bus_cycle_seq_test.sv
module bus_cycle_seq_test;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam logic [AW-1:0] PC0 = 8'hFC;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'd3;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] mem_wdata;
    logic          mem_rd, mem_wr, mem_ready, done;
    logic [DW-1:0] rd_byte, ir_out;
    logic [AW-1:0] pc_out;

    logic [DW-1:0] mem [256];
    int checks = 0;
    int fails = 0;
    int cyc = 0;

    logic [AW-1:0] m_pc;
    logic [DW-1:0] m_ir, m_data;

    always #2.5 clk = ~clk;

    assign mem_rdata = mem[mem_addr];

    bus_cycle_seq #(.ADDR_W(AW), .DATA_W(DW), .RESET_PC(PC0)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .mem_wdata(mem_wdata), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_ready(mem_ready), .done(done),
        .rd_byte(rd_byte), .ir_out(ir_out), .pc_out(pc_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_len(input int k, input int nw);
        return 3 + nw + ((k == 0) ? 1 : 0);
    endfunction

    task automatic run_cycle(input int k, input logic [AW-1:0] a,
                             input logic [DW-1:0] wd, input int nw, input bit noise);
        int clk_n = 0, rd_n = 0, wr_n = 0, done_n = 0, addr_bad = 0, wd_bad = 0;
        logic [AW-1:0] ea;
        logic [DW-1:0] fetched = '0;
        ea = (k == 0) ? m_pc : a;
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'(k); req_addr = a; req_wdata = wd;
        mem_ready = 1'b0;
        @(posedge clk);
        #1;
        if (noise) begin
            req_kind = 2'($urandom_range(0, 2));
            req_addr = 8'($urandom); req_wdata = 8'($urandom);
        end else req_valid = 1'b0;
        while (clk_n < 40) begin
            @(negedge clk);
            clk_n++;
            if (mem_rd) begin rd_n++; fetched = mem_rdata; end
            if (mem_wr) rd_n = rd_n;
            if (mem_wr) wr_n++;
            if ((mem_rd || mem_wr) && mem_addr != ea) addr_bad++;
            if (mem_wr && mem_wdata != wd) wd_bad++;
            mem_ready = ((rd_n + wr_n) > nw);
            if (done) begin
                done_n++;
                req_valid = 1'b0;
                if (k == 0) check(ir_out == fetched, "R8 ir on decode clock", ir_out, fetched);
                break;
            end
        end
        if (clk_n >= 40) check(1'b0, "watchdog", clk_n, 0);
        check(clk_n == exp_len(k, nw), (k == 0) ? "R2 fetch length" : "R3 rd/wr length",
              clk_n, exp_len(k, nw));
        check(rd_n == ((k != 2) ? 2 + nw : 0), "R5 read strobe clocks R4", rd_n, (k != 2) ? 2 + nw : 0);
        check(wr_n == ((k == 2) ? 2 + nw : 0), "R6 write strobe clocks R4", wr_n, (k == 2) ? 2 + nw : 0);
        check(addr_bad == 0, "R7 R4 address on bus", addr_bad, 0);
        check(wd_bad == 0, "R6 write data", wd_bad, 0);
        @(negedge clk);
        check(!done && !mem_rd && !mem_wr, "R9 idle after done", done, 0);
        if (k == 2) mem[a] = wd;
        else begin
            m_data = (k == 0) ? mem[m_pc] : mem[a];
            if (k == 0) m_ir = mem[m_pc];
        end
        if (k == 0) m_pc = m_pc + 1'b1;
        check(rd_byte == m_data, "R8 data register", rd_byte, m_data);
        check(ir_out == m_ir, "R8 instruction register", ir_out, m_ir);
        check(pc_out == m_pc, "R7 program counter", pc_out, m_pc);
        cyc++;
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
        mem_ready = 1'b0;
        m_pc = PC0; m_ir = '0; m_data = '0;
        repeat (3) @(negedge clk);
        check(!mem_rd && !mem_wr && !done, "R1 strobes in reset", {mem_rd, mem_wr, done}, 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check(!mem_rd && !mem_wr && !done, "R1 strobes after reset", {mem_rd, mem_wr, done}, 0);
        check(pc_out == PC0, "R1 reset pc", pc_out, PC0);
        check(ir_out == 0 && rd_byte == 0, "R1 reset registers", {ir_out, rd_byte}, 0);

        // directed: zero-wait cycles of each kind
        run_cycle(0, 8'h00, 8'h00, 0, 1'b0);
        run_cycle(1, 8'h10, 8'h00, 0, 1'b0);
        run_cycle(2, 8'h20, 8'hA5, 0, 1'b0);
        run_cycle(1, 8'h20, 8'h00, 0, 1'b0);
        check(rd_byte == 8'hA5, "R6 write read back", rd_byte, 8'hA5);
        // directed: wait states and busy noise, pc wrap R7
        run_cycle(0, 8'h00, 8'h00, 3, 1'b1);
        run_cycle(0, 8'h00, 8'h00, 1, 1'b0);
        run_cycle(0, 8'h00, 8'h00, 6, 1'b1);
        run_cycle(2, 8'h33, 8'h5A, 2, 1'b1);

        // R10: kind 3 starts nothing
        @(negedge clk);
        req_valid = 1'b1; req_kind = 2'd3; req_addr = 8'h44;
        begin
            int act = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk);
                if (mem_rd || mem_wr || done) act++;
            end
            req_valid = 1'b0;
            check(act == 0, "R10 kind 3 ignored", act, 0);
            check(pc_out == m_pc, "R10 pc unchanged", pc_out, m_pc);
        end

        // random mix
        for (int n = 0; n < 60; n++) begin
            run_cycle($urandom_range(0, 2), 8'($urandom), 8'($urandom),
                      $urandom_range(0, 5), 1'($urandom));
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #100000;
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule